// File: doc/BRIEF.md
# Ping-Pong LIFO Block Reverser

This block sits between the forward and the reverse delay chains of a symmetric FIR filter cell. It takes one sample per shift from a tap near the end of the forward chain and hands one sample per shift to the reverse chain. A filter with an odd tap count and one with an even tap count need different tap points for the pre-add to line up, so the block chooses its tap point from a mode input.

With reversal on, two LIFO banks take turns. One bank collects incoming samples while the other is drained top-first into the reverse chain. A transfer strobe swaps the two roles. The strobe first passes through a short internal delay, which is three clocks in even-tap mode and four in odd-tap mode. The distance between strobes therefore sets the length of each reversed block. The strobe pattern is expected to stay periodic and fixed once filtering is under way. With reversal off, the LIFOs stand idle and samples reach the reverse chain through a plain delay line whose length follows the decimation setting.

Top module: `block_reverser`

## Requirements
- R1: A synchronous reset drives `rev_out` to 0 and `overflow` to 0, empties both banks and makes bank 0 the write bank.
- R2: The feed sample is `pre_last` when `odd_taps` is 1 and `stage_out` when `odd_taps` is 0.
- R3: A strobe sampled high at clock edge e requests a swap at edge e+3 when `odd_taps` is 0 and at edge e+4 when `odd_taps` is 1. This delay counts clock edges whether or not `shift_en` is high.
- R4: A swap takes place only when the delayed request and `shift_en` are both high at the same edge. At that edge the output takes the top sample of the bank that was being written, the incoming sample becomes the only content of the other bank, and any samples left unread in that other bank are discarded.
- R5: With reversal on (`rev_en`=1) and strobes P edges apart, the output carries consecutive blocks of P samples in reversed order.
- R6: A shift that reads from an empty bank outputs 0.
- R7: An edge with `shift_en` low neither stores nor removes a sample, and `rev_out` holds its value.
- R8: Each bank holds at most 16 samples. A write into a full bank discards the sample and sets `overflow`, which stays at 1 until reset.
- R9: With reversal off (`rev_en`=0), `rev_out` after an enabled edge equals the feed sample taken `dec_factor` enabled edges earlier. When `dec_factor` is 0 it is the sample from that same edge. In this mode the strobe has no effect.
- R10: `rev_out` is registered and changes only at the edge of the shift that produces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Active-high shift enable for this edge |
| xfer | input | 1 | Active-high transfer strobe |
| rev_en | input | 1 | 1 = LIFO reversal, 0 = delay-line bypass |
| odd_taps | input | 1 | 1 = odd tap count, 0 = even tap count |
| dec_factor | input | 4 | Bypass delay setting, 0 to 15 |
| pre_last | input | 8 | Forward-stage sample taken one register before the stage output |
| stage_out | input | 8 | Forward-stage output sample |
| rev_out | output | 8 | Sample handed to the reverse chain |
| overflow | output | 1 | Sticky bank overflow flag |

## Verification
Most internal faults show up within one block length. A bank select that does not toggle replays stale or empty data immediately after the next swap. A wrong strobe delay moves the first non-zero output by one edge. An off-by-one pointer rotates the reversed order inside a block. Faults in the count logic surface later: a leaked count or an overflow threshold in the wrong place shows only when a seventeenth sample arrives, or when a missed swap lets one bank fill across two periods. The tests therefore run long unswapped stretches, idle cycles placed where a swap is due, and both tap modes with different data on the two feed inputs.

// File: rtl/block_reverser_pkg.sv
package block_reverser_pkg;

    localparam int DATA_W_DEF  = 8;
    localparam int DEPTH_DEF   = 16;
    localparam int DEC_W_DEF   = 4;
    localparam int EVEN_LAG    = 3;
    localparam int ODD_LAG     = 4;

    typedef enum logic {
        BANK0 = 1'b0,
        BANK1 = 1'b1
    } bank_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic bank_e other_bank(input bank_e b);
        return (b == BANK0) ? BANK1 : BANK0;
    endfunction

endpackage

// File: rtl/xfer_lag.sv
module xfer_lag
    import block_reverser_pkg::*;
#(
    parameter int EVEN_DLY = EVEN_LAG,
    parameter int ODD_DLY  = ODD_LAG
) (
    input  logic clk,
    input  logic rst,
    input  logic xfer,
    input  logic odd_taps,
    output logic swap_req
);
    localparam int LEN = max_int(max_int(EVEN_DLY, ODD_DLY), 2);

    logic [LEN-1:0] pipe;

    // pipe[i] holds the strobe sampled i+1 edges ago; it shifts every clock
    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[LEN-2:0], xfer};
    end

    assign swap_req = odd_taps ? pipe[ODD_DLY-1] : pipe[EVEN_DLY-1];

endmodule

// File: rtl/lifo_pair.sv
module lifo_pair
    import block_reverser_pkg::*;
#(
    parameter int DW    = DATA_W_DEF,
    parameter int DEPTH = DEPTH_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          swap,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q,
    output logic          ovf
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [2][DEPTH];
    logic [CW-1:0] cnt [2];
    bank_e         wsel;
    bank_e         rsel;
    bank_e         rd_bank;
    logic [CW-1:0] rd_cnt;
    logic [AW-1:0] rd_idx;
    logic [AW-1:0] wr_idx;
    logic          full;

    assign rsel    = other_bank(wsel);
    assign rd_bank = swap ? wsel : rsel;
    assign rd_cnt  = cnt[rd_bank];
    assign rd_idx  = AW'(rd_cnt - CW'(1));
    assign wr_idx  = AW'(cnt[wsel]);
    assign full    = (cnt[wsel] == CW'(DEPTH));

    // Control state: counts, bank select, output register, flag
    always_ff @(posedge clk) begin
        if (rst) begin
            wsel   <= BANK0;
            cnt[0] <= '0;
            cnt[1] <= '0;
            q      <= '0;
            ovf    <= 1'b0;
        end else if (en) begin
            if (rd_cnt != '0) begin
                q            <= mem[rd_bank][rd_idx];
                cnt[rd_bank] <= rd_cnt - CW'(1);
            end else begin
                q <= '0;
            end
            if (swap) begin
                wsel      <= rsel;
                cnt[rsel] <= CW'(1);
            end else if (!full) begin
                cnt[wsel] <= cnt[wsel] + CW'(1);
            end else begin
                ovf <= 1'b1;
            end
        end
    end

    // Sample storage, no reset needed
    always_ff @(posedge clk) begin
        if (en) begin
            if (swap)       mem[rsel][0]      <= din;
            else if (!full) mem[wsel][wr_idx] <= din;
        end
    end

    assert_depth_bound_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt[0] <= CW'(DEPTH)) && (cnt[1] <= CW'(DEPTH)));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        $past(ovf) |-> ovf);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));

    assert_empty_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (en && !swap && cnt[rsel] == '0) |=> (q == '0));

endmodule

// File: rtl/bypass_line.sv
module bypass_line
    import block_reverser_pkg::*;
#(
    parameter int DW    = DATA_W_DEF,
    parameter int DEC_W = DEC_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DEC_W-1:0] dec,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    q
);
    localparam int STAGES = (1 << DEC_W) - 1;

    logic [DW-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)     stg[0] <= '0;
                else if (en) stg[0] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)     stg[i] <= '0;
                else if (en) stg[i] <= stg[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= (dec == '0) ? din : stg[DEC_W'(dec - DEC_W'(1))];
    end

    assert_dec0_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (en && dec == '0) |=> (q == $past(din)));

endmodule

// File: rtl/block_reverser.sv
module block_reverser
    import block_reverser_pkg::*;
#(
    parameter int DW    = DATA_W_DEF,
    parameter int DEPTH = DEPTH_DEF,
    parameter int DEC_W = DEC_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             xfer,
    input  logic             rev_en,
    input  logic             odd_taps,
    input  logic [DEC_W-1:0] dec_factor,
    input  logic [DW-1:0]    pre_last,
    input  logic [DW-1:0]    stage_out,
    output logic [DW-1:0]    rev_out,
    output logic             overflow
);
    logic [DW-1:0] feed;
    logic          swap_req;
    logic [DW-1:0] lifo_q;
    logic [DW-1:0] byp_q;

    // Tap point: one register earlier for odd tap counts
    assign feed = odd_taps ? pre_last : stage_out;

    xfer_lag #(.EVEN_DLY(EVEN_LAG), .ODD_DLY(ODD_LAG)) u_lag (
        .clk      (clk),
        .rst      (rst),
        .xfer     (xfer),
        .odd_taps (odd_taps),
        .swap_req (swap_req)
    );

    lifo_pair #(.DW(DW), .DEPTH(DEPTH)) u_lifo (
        .clk  (clk),
        .rst  (rst),
        .en   (shift_en & rev_en),
        .swap (swap_req),
        .din  (feed),
        .q    (lifo_q),
        .ovf  (overflow)
    );

    bypass_line #(.DW(DW), .DEC_W(DEC_W)) u_byp (
        .clk (clk),
        .rst (rst),
        .en  (shift_en & ~rev_en),
        .dec (dec_factor),
        .din (feed),
        .q   (byp_q)
    );

    assign rev_out = rev_en ? lifo_q : byp_q;

endmodule

// File: tb/tb_block_reverser.sv
module tb_block_reverser;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shift_en = 1'b0;
    logic       xfer = 1'b0;
    logic       rev_en = 1'b1;
    logic       odd_taps = 1'b0;
    logic [3:0] dec_factor = 4'd0;
    logic [7:0] pre_last = 8'd0;
    logic [7:0] stage_out = 8'd0;
    logic [7:0] rev_out;
    logic       overflow;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    block_reverser dut (
        .clk(clk), .rst(rst), .shift_en(shift_en), .xfer(xfer),
        .rev_en(rev_en), .odd_taps(odd_taps), .dec_factor(dec_factor),
        .pre_last(pre_last), .stage_out(stage_out),
        .rev_out(rev_out), .overflow(overflow)
    );

    // {xfer, stage_out, expected rev_out}; even taps, strobe every 3 edges
    localparam logic [16:0] VEC [12] = '{
        {1'b1, 8'd10, 8'd0},  {1'b0, 8'd11, 8'd0},  {1'b0, 8'd12, 8'd0},
        {1'b1, 8'd13, 8'd12}, {1'b0, 8'd14, 8'd11}, {1'b0, 8'd15, 8'd10},
        {1'b1, 8'd16, 8'd15}, {1'b0, 8'd17, 8'd14}, {1'b0, 8'd18, 8'd13},
        {1'b1, 8'd19, 8'd18}, {1'b0, 8'd20, 8'd17}, {1'b0, 8'd21, 8'd16}
    };

    task automatic cyc(input logic sh, input logic xf, input logic [7:0] pl, input logic [7:0] so);
        shift_en  = sh;
        xfer      = xf;
        pre_last  = pl;
        stage_out = so;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_out(input logic [7:0] exp, input string req);
        tests++;
        if (rev_out !== exp) begin
            fails++;
            $display("FAIL %s rev_out actual=%0d expected=%0d", req, rev_out, exp);
        end
    endtask

    task automatic chk_ovf(input logic exp, input string req);
        tests++;
        if (overflow !== exp) begin
            fails++;
            $display("FAIL %s overflow actual=%0d expected=%0d", req, overflow, exp);
        end
    endtask

    task automatic do_reset(input logic rv, input logic od, input logic [3:0] dc);
        rst        = 1'b1;
        rev_en     = rv;
        odd_taps   = od;
        dec_factor = dc;
        cyc(1'b0, 1'b0, 8'd0, 8'd0);
        cyc(1'b0, 1'b0, 8'd0, 8'd0);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(1'b1, 1'b0, 4'd0);
        chk_out(8'd0, "R1");
        chk_ovf(1'b0, "R1");

        // R5 R3 R6 R2: table walk, even taps, period 3, pre_last is decoy data
        for (int k = 0; k < 12; k++) begin
            cyc(1'b1, VEC[k][16], 8'(200 + k), VEC[k][15:8]);
            chk_out(VEC[k][7:0], "R5");
        end

        // R3 R2 R4: odd taps take pre_last, swap lags strobe by 4; period 2
        do_reset(1'b1, 1'b1, 4'd0);
        for (int k = 0; k < 8; k++) begin
            cyc(1'b1, (k % 2) == 0, 8'(50 + k), 8'd255);
            if (k == 3) chk_out(8'd0,  "R3");
            if (k == 4) chk_out(8'd53, "R2");
            if (k == 5) chk_out(8'd52, "R4");
            if (k == 6) chk_out(8'd55, "R4");
            if (k == 7) chk_out(8'd54, "R4");
        end

        // R7: idle edge stores nothing and holds output
        do_reset(1'b1, 1'b0, 4'd0);
        cyc(1'b1, 1'b1, 8'd0, 8'd10);
        cyc(1'b1, 1'b0, 8'd0, 8'd11);
        cyc(1'b0, 1'b0, 8'd0, 8'd99);
        chk_out(8'd0, "R7");
        cyc(1'b1, 1'b0, 8'd0, 8'd13);
        chk_out(8'd11, "R7");
        cyc(1'b1, 1'b0, 8'd0, 8'd14);
        chk_out(8'd10, "R7");
        cyc(1'b1, 1'b0, 8'd0, 8'd15);
        chk_out(8'd0, "R6");

        // R4: delayed request during an idle edge is lost; bank keeps filling
        do_reset(1'b1, 1'b0, 4'd0);
        for (int k = 0; k < 13; k++) begin
            cyc(k != 3, (k == 0) || (k == 5), 8'd0, 8'(20 + k));
            if (k == 3)  chk_out(8'd0,  "R4");
            if (k == 4)  chk_out(8'd0,  "R4");
            if (k == 8)  chk_out(8'd27, "R4");
            if (k == 11) chk_out(8'd24, "R7");
            if (k == 12) chk_out(8'd22, "R7");
        end

        // R8: seventeenth sample overflows, flag sticks, excess dropped
        do_reset(1'b1, 1'b0, 4'd0);
        for (int k = 0; k < 21; k++) begin
            cyc(1'b1, k == 17, 8'd0, 8'(30 + k));
            if (k == 15) chk_ovf(1'b0, "R8");
            if (k == 16) chk_ovf(1'b1, "R8");
            if (k == 20) begin
                chk_out(8'd45, "R8");
                chk_ovf(1'b1, "R8");
            end
        end
        do_reset(1'b1, 1'b0, 4'd0);
        chk_ovf(1'b0, "R1");
        chk_out(8'd0, "R1");

        // R9: bypass with dec 2, strobe toggling has no effect
        do_reset(1'b0, 1'b0, 4'd2);
        for (int k = 0; k < 6; k++) begin
            cyc(1'b1, (k % 2) == 1, 8'd77, 8'(60 + k));
            if (k == 1) chk_out(8'd0,  "R9");
            if (k == 2) chk_out(8'd60, "R9");
            if (k == 5) chk_out(8'd63, "R9");
        end
        cyc(1'b0, 1'b1, 8'd77, 8'd90);
        chk_out(8'd63, "R7");

        // R9 R10: bypass with dec 0 registers the odd-tap feed on the same edge
        do_reset(1'b0, 1'b1, 4'd0);
        cyc(1'b1, 1'b1, 8'd41, 8'd3);
        chk_out(8'd41, "R10");
        cyc(1'b1, 1'b0, 8'd42, 8'd4);
        chk_out(8'd42, "R9");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule